// File: doc/BRIEF.md
# Sleep Entry and Wakeup Controller

This block decides what a retired SLEEP instruction does. A CPU sequencer pulses a strobe when SLEEP completes. The block looks at two control bits to choose the outcome. If the sleep-exception enable bit is clear, the block raises a registered power-down request for the clock-gating logic. It holds that request until a wake-capable interrupt arrives. When it does, the block drops the request and starts exception handling for the interrupt. If the enable bit is set, SLEEP never reaches power-down. It becomes a synchronous exception that cannot be masked, and execution later carries on at the instruction after SLEEP.

An interrupt can arrive just before SLEEP or in the same cycle. That interrupt belongs to the normal interrupt path, because it was serviced before the SLEEP retired. Only a wake request sampled while power-down is already active ends power-down. Every exception start is a single-cycle strobe with a one-bit vector select. Enabling the sleep exception is only legal while standby is not selected. If software breaks that rule, the exception is still taken and a sticky error flag is raised.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, powerDownReq, excStart, excVector, resume and cfgError are all 0 and the block is in the run state.
- R2: With sleepExcEn=0, a sleepStrobe sampled in the run state makes powerDownReq 1 from the next cycle on, with no excStart.
- R3: While powerDownReq is 1 and wakeReq is 0, powerDownReq stays 1 and excStart stays 0, for any number of cycles.
- R4: A wakeReq sampled while powerDownReq is 1 gives, in the next cycle, powerDownReq=0, excStart=1, excVector=0 (wake interrupt) and resume=1.
- R5: excStart is never high for two cycles in a row, and the block is back in the run state after the strobe.
- R6: With sleepExcEn=1, a sleepStrobe sampled in the run state gives excStart=1 with excVector=1 (sleep exception) in the next cycle. powerDownReq stays 0 throughout.
- R7: With sleepExcEn=0, a wakeReq sampled in the run state, including the same cycle as sleepStrobe, does not prevent or end the power-down that follows. Only a later wakeReq ends it.
- R8: With sleepExcEn=1, a wakeReq in the same cycle as sleepStrobe does not change the outcome: the sleep exception (excVector=1) is taken and power-down is never requested.
- R9: A sleepStrobe with sleepExcEn=1 and standbySel=1 still takes the sleep exception and sets cfgError. cfgError then stays 1 until reset.
- R10: standbySel=1 with sleepExcEn=0 leads to normal power-down and leaves cfgError at 0.
- R11: resume is 1 only in the cycle of a wake-interrupt exception start. It is never 1 for a sleep exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sleepStrobe | input | 1 | One-cycle pulse: a SLEEP instruction retired |
| sleepExcEn | input | 1 | 1 turns SLEEP into a sleep exception |
| standbySel | input | 1 | Standby-select control bit |
| wakeReq | input | 1 | One-cycle wake-capable interrupt request |
| powerDownReq | output | 1 | Registered clock-gate / power-down request |
| excStart | output | 1 | One-cycle exception-start strobe |
| excVector | output | 1 | Vector select with excStart: 0 wake interrupt, 1 sleep exception |
| resume | output | 1 | One-cycle indication that power-down has been left |
| cfgError | output | 1 | Sticky flag: sleep exception enabled while standby selected |

## Verification
A state register stuck in or skipping power-down shows up at the ports within one cycle of the SLEEP strobe. Either powerDownReq fails to rise, or an exception strobe appears instead. The tests therefore sample the outputs exactly one cycle after each strobe. A wrong choice of wake condition, such as treating a run-state interrupt as a wakeup, only shows once the block is sitting in power-down. The late-interrupt scenarios therefore hold power-down for several cycles and check that powerDownReq stays high. A lost dispatch state would show as a missing or two-cycle excStart, or as resume appearing on a sleep exception.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;

  typedef enum logic [1:0] {
    RUN          = 2'd0,
    POWER_DOWN   = 2'd1,
    EXC_DISPATCH = 2'd2
  } pwrState_t;

  localparam logic VEC_WAKE  = 1'b0;
  localparam logic VEC_SLEEP = 1'b1;

  // strobes from control to the output register datapath
  typedef struct packed {
    logic enterPd;   // request power-down from next cycle
    logic exitPd;    // drop power-down request
    logic fireExc;   // one-cycle exception start
    logic excSel;    // vector select for fireExc
    logic flagCfg;   // set sticky configuration error
  } ctlStrobe_t;

endpackage

// File: rtl/sleep_wake_fsm.sv
module sleep_wake_fsm
  import sleep_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepStrobe,
  input  logic       sleepExcEn,
  input  logic       standbySel,
  input  logic       wakeReq,
  output ctlStrobe_t strobes
);

  pwrState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    case (state)
      RUN: begin
        // a wake request seen here was already handled by the normal path
        if (sleepStrobe) begin
          if (sleepExcEn) begin
            stateNext       = EXC_DISPATCH;
            strobes.fireExc = 1'b1;
            strobes.excSel  = VEC_SLEEP;
            strobes.flagCfg = standbySel;
          end else begin
            stateNext       = POWER_DOWN;
            strobes.enterPd = 1'b1;
          end
        end
      end
      POWER_DOWN: begin
        if (wakeReq) begin
          stateNext       = EXC_DISPATCH;
          strobes.exitPd  = 1'b1;
          strobes.fireExc = 1'b1;
          strobes.excSel  = VEC_WAKE;
        end
      end
      EXC_DISPATCH: stateNext = RUN;
      default:      stateNext = RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= RUN;
    else       state <= stateNext;
  end

endmodule

// File: rtl/sleep_wake_regs.sv
module sleep_wake_regs
  import sleep_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobes,
  output logic       powerDownReq,
  output logic       excStart,
  output logic       excVector,
  output logic       resume,
  output logic       cfgError
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      powerDownReq <= 1'b0;
      excStart     <= 1'b0;
      excVector    <= 1'b0;
      resume       <= 1'b0;
      cfgError     <= 1'b0;
    end else begin
      if (strobes.enterPd)     powerDownReq <= 1'b1;
      else if (strobes.exitPd) powerDownReq <= 1'b0;
      excStart <= strobes.fireExc;
      if (strobes.fireExc) excVector <= strobes.excSel;
      resume <= strobes.exitPd;
      if (strobes.flagCfg) cfgError <= 1'b1;
    end
  end

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import sleep_wake_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic sleepStrobe,
  input  logic sleepExcEn,
  input  logic standbySel,
  input  logic wakeReq,
  output logic powerDownReq,
  output logic excStart,
  output logic excVector,
  output logic resume,
  output logic cfgError
);

  ctlStrobe_t strobes;

  sleep_wake_fsm i_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .sleepStrobe (sleepStrobe),
    .sleepExcEn  (sleepExcEn),
    .standbySel  (standbySel),
    .wakeReq     (wakeReq),
    .strobes     (strobes)
  );

  sleep_wake_regs i_regs (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .powerDownReq (powerDownReq),
    .excStart     (excStart),
    .excVector    (excVector),
    .resume       (resume),
    .cfgError     (cfgError)
  );

endmodule

// File: rtl/sleep_wake_checker.sv
module sleep_wake_checker (
  input logic clk,
  input logic rstN,
  input logic sleepStrobe,
  input logic sleepExcEn,
  input logic standbySel,
  input logic wakeReq,
  input logic powerDownReq,
  input logic excStart,
  input logic excVector,
  input logic resume,
  input logic cfgError
);

  logic inRun;
  assign inRun = !powerDownReq && !excStart;

  p_pd_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inRun && sleepStrobe && !sleepExcEn) |=> (powerDownReq && !excStart));

  p_pd_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (powerDownReq && !wakeReq) |=> (powerDownReq && !excStart));

  p_wake_exit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (powerDownReq && wakeReq) |=> (!powerDownReq && excStart && !excVector && resume));

  p_one_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    excStart |=> !excStart);

  p_sleep_exc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inRun && sleepStrobe && sleepExcEn) |=> (excStart && excVector && !powerDownReq));

  p_cfg_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inRun && sleepStrobe && sleepExcEn && standbySel) |=> cfgError);

  p_cfg_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError);

  p_resume_r11: assert property (@(posedge clk) disable iff (!rstN)
    resume |-> (excStart && !excVector));

endmodule

bind sleep_wake_ctrl sleep_wake_checker i_checker (
  .clk          (clk),
  .rstN         (rstN),
  .sleepStrobe  (sleepStrobe),
  .sleepExcEn   (sleepExcEn),
  .standbySel   (standbySel),
  .wakeReq      (wakeReq),
  .powerDownReq (powerDownReq),
  .excStart     (excStart),
  .excVector    (excVector),
  .resume       (resume),
  .cfgError     (cfgError)
);

// File: tb/test_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module test_sleep_wake_ctrl;

  logic clk = 1'b0;
  logic rstN, sleepStrobe, sleepExcEn, standbySel, wakeReq;
  logic powerDownReq, excStart, excVector, resume, cfgError;
  int   nChecks = 0;
  int   nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  sleep_wake_ctrl i_sleep_wake_ctrl (
    .clk(clk), .rstN(rstN), .sleepStrobe(sleepStrobe), .sleepExcEn(sleepExcEn),
    .standbySel(standbySel), .wakeReq(wakeReq), .powerDownReq(powerDownReq),
    .excStart(excStart), .excVector(excVector), .resume(resume), .cfgError(cfgError)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // outputs after one clock: drive at negedge, sample at the next negedge
  task automatic step(input logic slp, input logic en, input logic sb, input logic wk);
    sleepStrobe = slp; sleepExcEn = en; standbySel = sb; wakeReq = wk;
    @(negedge clk);
    sleepStrobe = 1'b0; wakeReq = 1'b0;
  endtask

  task automatic expectOut(input string req, input logic pd, input logic es,
                           input logic ev, input logic rs);
    check(req, "powerDownReq", powerDownReq, pd);
    check(req, "excStart", excStart, es);
    if (es) check(req, "excVector", excVector, ev);
    check(req, "resume", resume, rs);
  endtask

  task automatic tReset();
    rstN = 1'b0; sleepStrobe = 0; sleepExcEn = 0; standbySel = 0; wakeReq = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: everything idle after reset
    expectOut("R1", 0, 0, 0, 0);
    check("R1", "excVector", excVector, 1'b0);
    check("R1", "cfgError", cfgError, 1'b0);
  endtask

  task automatic tPowerDownWake();
    step(1, 0, 0, 0);
    expectOut("R2", 1, 0, 0, 0);
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 0, 0);
      expectOut("R3", 1, 0, 0, 0);
    end
    step(0, 0, 0, 1);
    expectOut("R4", 0, 1, 0, 1);
    step(0, 0, 0, 0);
    expectOut("R5", 0, 0, 0, 0);
    step(0, 0, 0, 0);
    expectOut("R5", 0, 0, 0, 0);
  endtask

  task automatic tLateIrq();
    // interrupt in run state one cycle before SLEEP, then together with SLEEP
    step(0, 0, 0, 1);
    expectOut("R7", 0, 0, 0, 0);
    step(1, 0, 0, 1);
    expectOut("R7", 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 0, 0);
      expectOut("R7", 1, 0, 0, 0);
    end
    step(0, 0, 0, 1);
    expectOut("R7", 0, 1, 0, 1);
    step(0, 0, 0, 0);
    expectOut("R5", 0, 0, 0, 0);
  endtask

  task automatic tSleepExc();
    step(1, 1, 0, 0);
    expectOut("R6", 0, 1, 1, 0);
    step(0, 1, 0, 0);
    expectOut("R6", 0, 0, 0, 0);
    step(0, 1, 0, 1);  // stray wake: back in run, not in power-down
    expectOut("R11", 0, 0, 0, 0);
    check("R6", "cfgError", cfgError, 1'b0);
  endtask

  task automatic tLateIrqExc();
    step(1, 1, 0, 1);
    expectOut("R8", 0, 1, 1, 0);
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 0, 0);
      expectOut("R8", 0, 0, 0, 0);
    end
  endtask

  task automatic tStandbyNoErr();
    step(1, 0, 1, 0);
    expectOut("R10", 1, 0, 0, 0);
    check("R10", "cfgError", cfgError, 1'b0);
    step(0, 0, 1, 1);
    expectOut("R10", 0, 1, 0, 1);
    step(0, 0, 0, 0);
    check("R10", "cfgError", cfgError, 1'b0);
  endtask

  task automatic tCfgError();
    step(1, 1, 1, 0);
    expectOut("R9", 0, 1, 1, 0);
    check("R9", "cfgError", cfgError, 1'b1);
    step(0, 0, 0, 0);
    check("R9", "cfgError sticky", cfgError, 1'b1);
    step(1, 0, 0, 0);
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    check("R9", "cfgError sticky after wake", cfgError, 1'b1);
    tReset();
    check("R9", "cfgError cleared by reset", cfgError, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    tReset();
    tPowerDownWake();
    tLateIrq();
    tSleepExc();
    tLateIrqExc();
    tStandbyNoErr();
    tCfgError();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule